// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block sits between a UART and an infrared transceiver. On the transmit side it turns each 0 data bit into one short active-high light pulse on `ir_tx`. A 1 bit produces no pulse. On the receive side it watches the active-low photodetector output `ir_rx_n`. It turns every falling edge into a 0 bit on `uart_rx_bit`, held for one full bit time. A quiet input reads as 1. The UART supplies its 16x baud clock enable `baud16_en`, so the block always knows where a bit starts. The link is half duplex: software transmits and receives at different times and provides any turnaround delay itself.

The pulse width has two modes. In normal mode the pulse covers three of the sixteen baud ticks of a bit, centred in the bit. In low-power mode the pulse lasts exactly three periods of a separate reference enable. An internal divider makes that enable from the system clock, dividing it by the value on `lp_div`. The divisor should put the reference strictly between 1.42 MHz and 2.12 MHz, nominally 1.8432 MHz. That gives a pulse of about 1.63 µs.

The transmit side is a state machine with the states IDLE, WAIT, ARM, PULSE and REST.
- IDLE to WAIT: a baud tick while the transmit bit is 0. This tick is the bit's tick 0.
- WAIT to PULSE: tick 7 in normal mode.
- WAIT to ARM: tick 7 in low-power mode.
- ARM to PULSE: the next reference enable.
- PULSE to REST: tick 10 in normal mode, or the third reference enable in low-power mode.
- Bit boundary: the tick after tick 15 is the next bit's tick 0. From any state other than IDLE it goes to WAIT if the bit is 0, otherwise to IDLE.

The receive side has the states IDLE and HOLD.
- IDLE to HOLD: a synchronised falling edge on `ir_rx_n`.
- HOLD to HOLD: a new falling edge restarts the tick count.
- HOLD to IDLE: the 16th baud tick after the edge.

Clearing `sir_en` sends both machines to IDLE.

Top module: `sir_endec`

## Requirements
- R1: After reset, `ir_tx` is 0 and `uart_rx_bit` is 1.
- R2: In normal mode, tick 0 of a 0 bit is the baud tick at which `uart_tx_bit` is first seen at 0. Tick k of that bit is the k-th baud tick after it. `ir_tx` rises in the clock after tick 7 and falls in the clock after tick 10. The pulse lasts three tick periods.
- R3: A 1 bit gives no pulse. Each bit in a run of 0 bits gives its own pulse, with bits 16 ticks apart.
- R4: In low-power mode, the pulse of a 0 bit rises in the clock after the first reference enable that follows tick 7. It lasts exactly three reference periods.
- R5: For a nonzero `lp_div` value D, the reference enable recurs every D system clocks. D = 1 gives an enable on every clock.
- R6: With `lp_div` = 0, low-power mode sends no pulses at all.
- R7: The raw input passes through a two-stage synchroniser. When `ir_rx_n` is driven low before clock edge A, `uart_rx_bit` is 0 from the clock after edge A+2. It stays 0 until the 16th baud tick after that edge.
- R8: A new falling edge during a hold restarts the 16-tick hold from that edge. `uart_rx_bit` does not rise in between.
- R9: Only falling edges start a hold. A quiet input keeps `uart_rx_bit` at 1. An input held low longer than the hold still releases `uart_rx_bit` to 1 after 16 ticks.
- R10: With `sir_en` at 0, `ir_tx` stays 0 whatever is transmitted, and `uart_rx_bit` stays 1 whatever is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uart_tx_bit | input | 1 | Serial transmit bit from the UART |
| baud16_en | input | 1 | One-clock enable at sixteen times the baud rate |
| sir_en | input | 1 | Enables encoder and decoder |
| lowpwr_sel | input | 1 | 1 selects the fixed low-power pulse width |
| lp_div | input | 8 | Divisor for the low-power reference (0 = stopped) |
| ir_rx_n | input | 1 | Raw photodetector input, low while light is received |
| ir_tx | output | 1 | Encoded infrared output, high during a light pulse |
| uart_rx_bit | output | 1 | Decoded serial receive bit to the UART |

## Verification
The bench samples `ir_tx` on every clock of every transmitted bit and compares it with the tick 7 to tick 10 window. A design that misplaced the pulse by one tick, widened it, or fired it on 1 bits would show a mismatch in that bit.
- Low-power mode is run with divisors 1, 3, 5 and 0. A divider off by one, or a pulse counter that stopped after two or four reference periods, would give the wrong width. A divider that ran with a zero divisor would emit pulses.
- On receive, the bench checks the exact first low clock after the synchroniser and the exact release tick. It also checks a second pulse in mid-hold, where a decoder without restart would release early. It checks a very long low input, where a level-sensitive decoder would stay at 0.
- With the block disabled, any pulse or decoded 0 counts as an error.

// File: rtl/sir_endec_pkg.sv
package sir_endec_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int PULSE_START   = 7;
    localparam int PULSE_TICKS   = 3;
    localparam int LP_PERIODS    = 3;
    localparam int DIV_WIDTH     = 8;
    localparam int SYNC_STAGES   = 2;

    typedef enum logic [2:0] {
        ENC_IDLE,
        ENC_WAIT,
        ENC_ARM,
        ENC_PULSE,
        ENC_REST
    } enc_state_t;

    typedef enum logic {
        DEC_IDLE,
        DEC_HOLD
    } dec_state_t;

endpackage

// File: rtl/sir_lp_divider.sv
module sir_lp_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             lp_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             div_zero;
    logic [DIV_W-1:0] last_cnt;

    assign div_zero = (divisor == '0);
    assign last_cnt = divisor - DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (div_zero || cnt_q >= last_cnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign lp_tick = !div_zero && (cnt_q == last_cnt);

endmodule

// File: rtl/sir_encoder.sv
module sir_encoder
    import sir_endec_pkg::*;
#(
    parameter int TICKS      = 16,
    parameter int START      = 7,
    parameter int WIDTH      = 3,
    parameter int LP_COUNT   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic lowpwr,
    input  logic tick,
    input  logic lp_tick,
    input  logic tx_bit,
    output logic ir_out
);

    localparam int PH_W  = $clog2(TICKS);
    localparam int LPC_W = $clog2(LP_COUNT + 1);
    localparam logic [PH_W-1:0]  PH_ON   = PH_W'(START);
    localparam logic [PH_W-1:0]  PH_OFF  = PH_W'(START + WIDTH);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(TICKS - 1);
    localparam logic [LPC_W-1:0] LPC_END = LPC_W'(LP_COUNT - 1);

    enc_state_t        st_q, st_d;
    logic [PH_W-1:0]   ph_q, ph_d;
    logic [LPC_W-1:0]  lpc_q, lpc_d;
    logic              at_boundary;

    assign at_boundary = tick && (st_q != ENC_IDLE) && (ph_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ENC_IDLE;
            ph_q  <= '0;
            lpc_q <= '0;
        end else begin
            st_q  <= st_d;
            ph_q  <= ph_d;
            lpc_q <= lpc_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        ph_d  = ph_q;
        lpc_d = lpc_q;
        if (!enable) begin
            st_d  = ENC_IDLE;
            ph_d  = '0;
            lpc_d = '0;
        end else begin
            if (tick && st_q != ENC_IDLE) begin
                ph_d = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
            end
            unique case (st_q)
                ENC_IDLE: begin
                    ph_d = '0;
                    if (tick && !tx_bit) begin
                        st_d = ENC_WAIT;
                        ph_d = PH_W'(1);
                    end
                end
                ENC_WAIT: begin
                    if (tick && ph_q == PH_ON) begin
                        st_d = lowpwr ? ENC_ARM : ENC_PULSE;
                    end
                end
                ENC_ARM: begin
                    if (lp_tick) begin
                        st_d  = ENC_PULSE;
                        lpc_d = '0;
                    end
                end
                ENC_PULSE: begin
                    if (lowpwr) begin
                        if (lp_tick) begin
                            if (lpc_q == LPC_END) st_d = ENC_REST;
                            else                  lpc_d = lpc_q + LPC_W'(1);
                        end
                    end else if (tick && ph_q == PH_OFF) begin
                        st_d = ENC_REST;
                    end
                end
                ENC_REST: begin
                    st_d = ENC_REST;
                end
            endcase
            if (at_boundary) begin
                st_d = tx_bit ? ENC_IDLE : ENC_WAIT;
                ph_d = tx_bit ? '0 : PH_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        ir_out = enable && (st_q == ENC_PULSE);
    end

endmodule

// File: rtl/sir_decoder.sv
module sir_decoder
    import sir_endec_pkg::*;
#(
    parameter int TICKS = 16,
    parameter int SYNC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic ir_in_n,
    output logic rx_bit
);

    localparam int CNT_W = $clog2(TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS - 1);

    logic [SYNC-1:0]  sync_q;
    logic             prev_q;
    logic             fall;
    dec_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], ir_in_n};
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign fall = prev_q && !sync_q[SYNC-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DEC_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!enable) begin
            st_d  = DEC_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                DEC_IDLE: begin
                    if (fall) begin
                        st_d  = DEC_HOLD;
                        cnt_d = '0;
                    end
                end
                DEC_HOLD: begin
                    if (fall) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q == CNT_LAST) begin
                            st_d  = DEC_IDLE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rx_bit = !(enable && st_q == DEC_HOLD);
    end

endmodule

// File: rtl/sir_endec.sv
module sir_endec
    import sir_endec_pkg::*;
#(
    parameter int TICKS_BIT  = TICKS_PER_BIT,
    parameter int PULSE_AT   = PULSE_START,
    parameter int PULSE_LEN  = PULSE_TICKS,
    parameter int LP_PULSES  = LP_PERIODS,
    parameter int DIV_W      = DIV_WIDTH,
    parameter int SYNC_DEPTH = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uart_tx_bit,
    input  logic             baud16_en,
    input  logic             sir_en,
    input  logic             lowpwr_sel,
    input  logic [DIV_W-1:0] lp_div,
    input  logic             ir_rx_n,
    output logic             ir_tx,
    output logic             uart_rx_bit
);

    logic lp_tick;

    sir_lp_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (lp_div),
        .lp_tick (lp_tick)
    );

    sir_encoder #(
        .TICKS    (TICKS_BIT),
        .START    (PULSE_AT),
        .WIDTH    (PULSE_LEN),
        .LP_COUNT (LP_PULSES)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (sir_en),
        .lowpwr  (lowpwr_sel),
        .tick    (baud16_en),
        .lp_tick (lp_tick),
        .tx_bit  (uart_tx_bit),
        .ir_out  (ir_tx)
    );

    sir_decoder #(
        .TICKS (TICKS_BIT),
        .SYNC  (SYNC_DEPTH)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (sir_en),
        .tick    (baud16_en),
        .ir_in_n (ir_rx_n),
        .rx_bit  (uart_rx_bit)
    );

endmodule

// File: rtl/sir_endec_chk.sv
module sir_endec_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sir_en,
    input logic             lowpwr_sel,
    input logic [DIV_W-1:0] lp_div,
    input logic             ir_rx_n,
    input logic             ir_tx,
    input logic             uart_rx_bit
);

    // R10
    ir_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sir_en |=> !ir_tx);

    // R10
    rx_idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sir_en |=> uart_rx_bit);

    // R2
    pulse_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n || !sir_en)
        $rose(ir_tx) |=> ir_tx);

    // R6
    no_pulse_zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx) |-> !($past(lowpwr_sel) && ($past(lp_div) == '0)));

    // R7
    rx_fall_needs_light_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uart_rx_bit) |-> !$past(ir_rx_n, 3));

endmodule

bind sir_endec sir_endec_chk #(.DIV_W(DIV_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sir_en      (sir_en),
    .lowpwr_sel  (lowpwr_sel),
    .lp_div      (lp_div),
    .ir_rx_n     (ir_rx_n),
    .ir_tx       (ir_tx),
    .uart_rx_bit (uart_rx_bit)
);

// File: tb/test_sir_endec.sv
`timescale 1ns/1ps
module test_sir_endec;

    localparam int N  = 8;       // clocks per baud16 tick
    localparam int BT = 16 * N;  // clocks per bit

    logic       clk = 1'b0;
    logic       rst_n;
    logic       uart_tx_bit;
    logic       baud16_en;
    logic       sir_en;
    logic       lowpwr_sel;
    logic [7:0] lp_div;
    logic       ir_rx_n;
    logic       ir_tx;
    logic       uart_rx_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sir_endec i_sir_endec (
        .clk         (clk),
        .rst_n       (rst_n),
        .uart_tx_bit (uart_tx_bit),
        .baud16_en   (baud16_en),
        .sir_en      (sir_en),
        .lowpwr_sel  (lowpwr_sel),
        .lp_div      (lp_div),
        .ir_rx_n     (ir_rx_n),
        .ir_tx       (ir_tx),
        .uart_rx_bit (uart_rx_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Transmit a frame of nb bits, LSB first; checks each bit
    task automatic enc_frame(input logic [15:0] bits, input int nb, input bit lp,
                             input int d, input bit on, input string tag);
        sir_en     = on;
        lowpwr_sel = lp;
        lp_div     = 8'(d);
        for (int b = 0; b < nb; b++) begin
            int hi = 0;
            int first = -1;
            int last = -1;
            int mism = 0;
            int exp_hi;
            logic bv = bits[b];
            for (int c = 0; c < BT; c++) begin
                @(negedge clk);
                if (c > 0) begin
                    bit e = on && !bv && !lp && (c >= 7*N + 1) && (c <= 10*N);
                    if (ir_tx) begin
                        hi++;
                        if (first < 0) first = c;
                        last = c;
                    end
                    if (!lp && (ir_tx !== e)) mism++;
                end
                baud16_en   = (c % N == 0);
                uart_tx_bit = bv;
            end
            if (!on || bv || (lp && d == 0)) begin
                exp_hi = 0;
            end else begin
                exp_hi = lp ? 3*d : 3*N;
            end
            if (!lp) begin
                check(mism == 0, tag, hi, exp_hi);
            end else begin
                check(hi == exp_hi, tag, hi, exp_hi);
                if (exp_hi > 0) begin
                    check(first >= 7*N + 2 && first <= 7*N + 1 + d, tag, first, 7*N + 2);
                    check(last - first + 1 == hi, tag, last - first + 1, hi);
                end
            end
        end
        @(negedge clk);
        baud16_en   = 1'b0;
        uart_tx_bit = 1'b1;
    endtask

    // Receive: falling edges at s1 and s2 (negative = none), each low for plen clocks
    task automatic dec_case(input int s1, input int s2, input int plen,
                            input bit on, input string tag);
        int mism = 0;
        int bad_c = -1;
        int bad_v = 0;
        int last_s = (s2 >= 0) ? s2 : s1;
        sir_en = on;
        for (int c = 0; c < 28*N; c++) begin
            @(negedge clk);
            if (c > 0) begin
                bit exp_low = on && (s1 >= 0) && (c >= s1 + 3) && (c <= last_s + 16*N);
                if (uart_rx_bit !== !exp_low) begin
                    mism++;
                    if (bad_c < 0) begin
                        bad_c = c;
                        bad_v = uart_rx_bit;
                    end
                end
            end
            baud16_en = (c % N == 0);
            ir_rx_n = !(((s1 >= 0) && c >= s1 && c < s1 + plen) ||
                        ((s2 >= 0) && c >= s2 && c < s2 + plen));
        end
        check(mism == 0, tag, bad_v, (bad_c < 0) ? 0 : ~bad_v & 1);
        if (bad_c >= 0) $display("  first mismatch at clock %0d", bad_c);
        @(negedge clk);
        baud16_en = 1'b0;
        ir_rx_n   = 1'b1;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(ir_tx == 1'b0, "R1 ir_tx after reset", ir_tx, 0);
        check(uart_rx_bit == 1'b1, "R1 rx after reset", uart_rx_bit, 1);
    endtask

    task automatic test_normal();
        enc_frame(16'b0000_0000_0011_0010, 6, 1'b0, 0, 1'b1, "R2/R3 normal mixed");
        enc_frame(16'b0000_0000_1100_0000, 8, 1'b0, 0, 1'b1, "R2/R3 normal zero run");
    endtask

    task automatic test_lowpower();
        enc_frame(16'b0000_0000_0000_0110, 4, 1'b1, 3, 1'b1, "R4/R5 lp div3");
        enc_frame(16'b0000_0000_0000_0010, 3, 1'b1, 1, 1'b1, "R4/R5 lp div1");
        enc_frame(16'b0000_0000_0000_0100, 3, 1'b1, 5, 1'b1, "R4/R5 lp div5");
        enc_frame(16'b0000_0000_0000_0100, 3, 1'b1, 0, 1'b1, "R6 lp div0");
    endtask

    task automatic test_disabled();
        enc_frame(16'b0000_0000_0000_0100, 3, 1'b0, 0, 1'b0, "R10 tx disabled");
        dec_case(0, -1, 3, 1'b0, "R10 rx disabled");
        sir_en = 1'b1;
    endtask

    task automatic test_decode();
        dec_case(0, -1, 3, 1'b1, "R7 single pulse");
        dec_case(0, 8*N, 3, 1'b1, "R8 retrigger");
        dec_case(0, -1, 20*N, 1'b1, "R9 long low");
        dec_case(-1, -1, 0, 1'b1, "R9 quiet input");
    endtask

    initial begin
        rst_n       = 1'b0;
        uart_tx_bit = 1'b1;
        baud16_en   = 1'b0;
        sir_en      = 1'b1;
        lowpwr_sel  = 1'b0;
        lp_div      = 8'd3;
        ir_rx_n     = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_normal();
        test_lowpower();
        test_decode();
        test_disabled();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule